// File: doc/BRIEF.md
# Pixel Line Rasteriser

This block rasterises one straight segment between two integer endpoints into a linear frame-store address space. A command carries a start point and an end point. Once it is taken, the block issues one pixel write per clock: a linear address and a write strobe. No colour or data path is involved. A `busy` flag covers the whole segment, and a single-cycle `done` pulse follows the final write.

Every direction is supported. The longer of the two coordinate spans becomes the driving axis, which advances on every pixel. The other axis advances only when an integer error accumulator says so. Step signs come from the direction of travel. Because of this, the error update, the step decision and the address update all settle in the same clock that presents the current pixel.

Coordinates are converted to an address only once, when the command is accepted. After that the block moves a running address by ±1 for a horizontal step and ±row pitch for a vertical step. No coordinate is kept, so nothing is clipped.

Top module: `line_raster_engine`

## Requirements
- R1: While reset is held, and on the first cycles after it is released, `busy`, `done` and `wr_en` are all 0.
- R2: If `start` is 1 at a rising edge while `busy` is 0, the command is taken. In the cycle after that edge, `busy` and `wr_en` are 1, and `wr_addr` equals y0*640 + x0.
- R3: A segment produces exactly N+1 writes in consecutive cycles, where N = max(|x1-x0|, |y1-y0|). Both endpoints are included.
- R4: The error term starts at -N. Let D be the span of the other axis, and let t = e + 2D. If t >= 0, the other axis steps and e becomes t - 2N. Otherwise e becomes t. The driving axis steps on every pixel.
- R5: The driving axis is y when |y1-y0| > |x1-x0|, and x otherwise, so a 45° tie counts as x. Each axis steps towards its own endpoint.
- R6: Consecutive write addresses differ by +1 or -1 for an x step, by +640 or -640 for a y step, or by the sum of one of each.
- R7: `done` is 1 for exactly one cycle, the cycle after the last write. In that cycle `busy` and `wr_en` are 0.
- R8: A `start` that arrives while `busy` is 1 has no effect. The running segment keeps its address sequence, and no further writes follow its `done`.
- R9: When both endpoints are equal, the block makes exactly one write, at the start address.
- R10: The address is y*640 + x even when x is 640 or more. A run past the right edge therefore continues into the next row without clipping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Command strobe; taken only while idle |
| x0 | input | 10 | Start x |
| y0 | input | 9 | Start y |
| x1 | input | 10 | End x |
| y1 | input | 9 | End y |
| busy | output | 1 | High from the cycle after acceptance through the last write |
| done | output | 1 | One-cycle pulse after the last write |
| wr_en | output | 1 | Pixel write strobe |
| wr_addr | output | 19 | Linear pixel address of the current write |

## Verification
The hardest cases to reach from the ports are the error decisions right at t = 0 and the octants with negative steps, where a sign slip still produces a plausible-looking line. The stimulus drives segments into all eight octants from a common centre, plus exact diagonals and shallow and steep near-ties. Every address is compared against an independent model. A second `start` is also injected in the middle of a long segment to show that the running sequence is left alone.

// File: rtl/line_pkg.sv
package line_pkg;

  // Which coordinate advances on every pixel.
  typedef enum logic {
    AXIS_X = 1'b0,
    AXIS_Y = 1'b1
  } axis_e;

  // Row pitch of the frame store, in pixels.
  localparam int ROW_PITCH = 640;

endpackage

// File: rtl/line_setup.sv
// Decodes a command into driving/secondary spans, per-step address
// increments and the linear start address. Purely combinational.
module line_setup
  import line_pkg::*;
#(
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int MW    = 10,
  parameter int AW    = 19,
  parameter int PITCH = ROW_PITCH
) (
  input  logic [XW-1:0] x0,
  input  logic [YW-1:0] y0,
  input  logic [XW-1:0] x1,
  input  logic [YW-1:0] y1,
  output logic [MW-1:0] span_major,
  output logic [MW-1:0] span_minor,
  output logic [AW-1:0] inc_major,
  output logic [AW-1:0] inc_minor,
  output logic [AW-1:0] base_addr
);

  logic signed [XW:0] diff_x;
  logic signed [YW:0] diff_y;
  logic        [XW:0] neg_x;
  logic        [YW:0] neg_y;
  logic [XW-1:0]      mag_x;
  logic [YW-1:0]      mag_y;
  logic [MW-1:0]      mag_x_w;
  logic [MW-1:0]      mag_y_w;
  logic [AW-1:0]      inc_x;
  logic [AW-1:0]      inc_y;
  logic [AW-1:0]      row_base;
  axis_e              drive_axis;

  // Signed spans and their magnitudes.
  always_comb begin
    diff_x = $signed({1'b0, x1}) - $signed({1'b0, x0});
    diff_y = $signed({1'b0, y1}) - $signed({1'b0, y0});
    neg_x  = -diff_x;
    neg_y  = -diff_y;
    mag_x  = diff_x[XW] ? neg_x[XW-1:0] : diff_x[XW-1:0];
    mag_y  = diff_y[YW] ? neg_y[YW-1:0] : diff_y[YW-1:0];
    mag_x_w = MW'(mag_x);
    mag_y_w = MW'(mag_y);
  end

  // Per-axis address increments: +/-1 horizontally, +/-pitch vertically.
  always_comb begin
    inc_x = diff_x[XW] ? {AW{1'b1}} : AW'(1);
    inc_y = diff_y[YW] ? (AW'(0) - AW'(PITCH)) : AW'(PITCH);
  end

  // Axis selection: strictly steeper than 45 degrees drives on y.
  always_comb begin
    drive_axis = (mag_y_w > mag_x_w) ? AXIS_Y : AXIS_X;
    if (drive_axis == AXIS_Y) begin
      span_major = mag_y_w;
      span_minor = mag_x_w;
      inc_major  = inc_y;
      inc_minor  = inc_x;
    end else begin
      span_major = mag_x_w;
      span_minor = mag_y_w;
      inc_major  = inc_x;
      inc_minor  = inc_y;
    end
  end

  // Row base: shift-and-add when the pitch is 512 + 128.
  generate
    if (PITCH == 640) begin : g_pitch_shift
      always_comb row_base = (AW'(y0) << 9) + (AW'(y0) << 7);
    end else begin : g_pitch_mul
      always_comb row_base = AW'(y0) * AW'(PITCH);
    end
  endgenerate

  always_comb base_addr = row_base + AW'(x0);

  // R5: the driving span is never the shorter one.
  always_comb begin
    AST_MAJOR_DOMINATES: assert (span_major >= span_minor); // R5
  end

endmodule

// File: rtl/line_err_step.sv
// Integer error accumulator: one decision and update per clock.
module line_err_step #(
  parameter int MW = 10,
  parameter int EW = MW + 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [MW-1:0] span_major,
  input  logic [MW-1:0] span_minor,
  output logic          minor_step
);

  logic signed [EW-1:0] err_q,  err_d;
  logic signed [EW-1:0] twom_q, twom_d;
  logic signed [EW-1:0] twon_q, twon_d;
  logic signed [EW-1:0] trial;
  logic                 err_en;

  // Decision: trial = e + 2*minor; step the minor axis when trial >= 0.
  always_comb begin
    trial      = err_q + twon_q;
    minor_step = ~trial[EW-1];
  end

  always_comb begin
    err_en = load | adv;
    err_d  = err_q;
    twom_d = twom_q;
    twon_d = twon_q;
    if (load) begin
      err_d  = -$signed({3'b000, span_major});
      twom_d = $signed({2'b00, span_major, 1'b0});
      twon_d = $signed({2'b00, span_minor, 1'b0});
    end else if (adv) begin
      err_d = minor_step ? (trial - twom_q) : trial;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q  <= '0;
      twom_q <= '0;
      twon_q <= '0;
    end else if (err_en) begin
      err_q  <= err_d;
      twom_q <= twom_d;
      twon_q <= twon_d;
    end
  end

  // R4: with a non-zero driving span the error stays in [-2N, 0).
  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && twom_q != 0) |-> (err_q < 0 && err_q >= -twom_q)); // R4

endmodule

// File: rtl/line_addr_walk.sv
// Running linear address: advanced by increments, never by coordinates.
module line_addr_walk #(
  parameter int AW    = 19,
  parameter int PITCH = 640
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic          minor_step,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] inc_major,
  input  logic [AW-1:0] inc_minor,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;
  logic [AW-1:0] incj_q, incj_d;
  logic [AW-1:0] incn_q, incn_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | adv;
    addr_d  = addr_q;
    incj_d  = incj_q;
    incn_d  = incn_q;
    if (load) begin
      addr_d = base_addr;
      incj_d = inc_major;
      incn_d = inc_minor;
    end else if (adv) begin
      addr_d = addr_q + incj_q + (minor_step ? incn_q : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      incj_q <= '0;
      incn_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
      incj_q <= incj_d;
      incn_q <= incn_d;
    end
  end

  assign addr = addr_q;

  function automatic logic legal_step(input logic [AW-1:0] d);
    legal_step = (d == AW'(1)) || (d == -AW'(1)) ||
                 (d == AW'(PITCH)) || (d == -AW'(PITCH)) ||
                 (d == AW'(PITCH + 1)) || (d == AW'(PITCH - 1)) ||
                 (d == -AW'(PITCH + 1)) || (d == -AW'(PITCH - 1));
  endfunction

  AST_STEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && $past(adv)) |-> legal_step(addr_q - $past(addr_q))); // R6

endmodule

// File: rtl/line_raster_engine.sv
// Top: command acceptance, pixel countdown, busy/done and write port.
module line_raster_engine
  import line_pkg::*;
#(
  parameter int XW    = 10,
  parameter int YW    = 9,
  parameter int PITCH = ROW_PITCH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [XW-1:0]       x0,
  input  logic [YW-1:0]       y0,
  input  logic [XW-1:0]       x1,
  input  logic [YW-1:0]       y1,
  output logic                busy,
  output logic                done,
  output logic                wr_en,
  output logic [$clog2(PITCH * (2 ** YW))-1:0] wr_addr
);

  localparam int MW = (XW >= YW) ? XW : YW;
  localparam int EW = MW + 3;
  localparam int AW = $clog2(PITCH * (2 ** YW));

  // Reset: asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [MW-1:0] span_major, span_minor;
  logic [AW-1:0] inc_major, inc_minor, base_addr;
  logic          minor_step;
  logic          accept;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [MW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [AW-1:0] addr;

  line_setup #(
    .XW(XW), .YW(YW), .MW(MW), .AW(AW), .PITCH(PITCH)
  ) u_setup (
    .x0         (x0),
    .y0         (y0),
    .x1         (x1),
    .y1         (y1),
    .span_major (span_major),
    .span_minor (span_minor),
    .inc_major  (inc_major),
    .inc_minor  (inc_minor),
    .base_addr  (base_addr)
  );

  line_err_step #(
    .MW(MW), .EW(EW)
  ) u_err (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (accept),
    .adv        (busy_q),
    .span_major (span_major),
    .span_minor (span_minor),
    .minor_step (minor_step)
  );

  line_addr_walk #(
    .AW(AW), .PITCH(PITCH)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load       (accept),
    .adv        (busy_q),
    .minor_step (minor_step),
    .base_addr  (base_addr),
    .inc_major  (inc_major),
    .inc_minor  (inc_minor),
    .addr       (addr)
  );

  // Control next state.
  always_comb begin
    accept = start & ~busy_q;
    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    cnt_en = accept | busy_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = span_major;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign wr_en   = busy_q;
  assign wr_addr = addr;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!busy && !wr_en)); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && cnt_q != '0) |=> (busy && cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start && cnt_q != '0) |=> (busy && !done)); // R8
  AST_ACCEPT_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start && !busy) |=> (busy && wr_en)); // R2

endmodule

// File: tb/line_raster_engine_bench.sv
module line_raster_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PITCH      = 640;
  localparam int AWB        = 19;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [9:0]  x0, x1;
  logic [8:0]  y0, y1;
  logic        busy, done, wr_en;
  logic [18:0] wr_addr;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc   = 0;
  int    exp_q[$];
  string cur_tag = "R1";
  bit    mon_on = 1'b0;

  line_raster_engine u_line_raster_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .x0      (x0),
    .y0      (y0),
    .x1      (x1),
    .y1      (y1),
    .busy    (busy),
    .done    (done),
    .wr_en   (wr_en),
    .wr_addr (wr_addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Watchdog.
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // Monitor: pop and compare every write.
  always @(negedge clk) begin
    if (mon_on && wr_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_tag, " unexpected write"}, int'(wr_addr), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(wr_addr) == e, {cur_tag, " address"}, int'(wr_addr), e);
      end
    end
  end

  // Reference from the requirements (R4, R5, R10): pushes expected addresses.
  function automatic int model(input int ax0, ay0, ax1, ay1);
    int adx, ady, sx, sy, nmaj, nmin, e, t, x, y;
    bit ymaj;
    adx = (ax1 >= ax0) ? ax1 - ax0 : ax0 - ax1;
    ady = (ay1 >= ay0) ? ay1 - ay0 : ay0 - ay1;
    sx  = (ax1 >= ax0) ? 1 : -1;
    sy  = (ay1 >= ay0) ? 1 : -1;
    ymaj = ady > adx;
    nmaj = ymaj ? ady : adx;
    nmin = ymaj ? adx : ady;
    x = ax0; y = ay0; e = -nmaj;
    exp_q.push_back((y * PITCH + x) % (1 << AWB));
    for (int i = 0; i < nmaj; i++) begin
      t = e + 2 * nmin;
      if (t >= 0) begin
        if (ymaj) x += sx; else y += sy;
        e = t - 2 * nmaj;
      end else begin
        e = t;
      end
      if (ymaj) y += sy; else x += sx;
      exp_q.push_back((y * PITCH + x) % (1 << AWB));
    end
    return nmaj;
  endfunction

  task automatic draw(input int ax0, ay0, ax1, ay1, input string tag, input bit poke);
    int nmaj, n;
    cur_tag = tag;
    nmaj = model(ax0, ay0, ax1, ay1);
    @(negedge clk);
    x0 = 10'(ax0); y0 = 9'(ay0); x1 = 10'(ax1); y1 = 9'(ay1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", int'(busy), 1);
    chk(wr_en === 1'b1 && int'(wr_addr) == ay0 * PITCH + ax0,
        "R2 first address", int'(wr_addr), ay0 * PITCH + ax0);
    n = 0;
    while (done !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin
        x0 = 10'd5; y0 = 9'd5; x1 = 10'd9; y1 = 9'd6; start = 1'b1;
      end
      if (poke && n == 4) start = 1'b0;
    end
    chk(n == nmaj + 1, {tag, " R3 cycles to done"}, n, nmaj + 1);
    chk(busy === 1'b0 && wr_en === 1'b0, "R7 idle with done", int'(busy), 0);
    chk(exp_q.size() == 0, {tag, " R3 write count"}, exp_q.size(), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done single cycle", int'(done), 0);
    if (poke) begin
      repeat (3) begin
        chk(wr_en === 1'b0, "R8 no writes after ignored start", int'(wr_en), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0;
    x0 = '0; y0 = '0; x1 = '0; y1 = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "R1 in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && wr_en === 1'b0, "R1 after release", int'(wr_en), 0);
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    draw(0, 0, 10, 4, "R4 base octant", 1'b0);
    draw(2, 1, 6, 3, "R4 half-slope tie", 1'b0);
    // R5: eight octants from a common centre.
    draw(300, 200, 320, 207, "R5 oct0", 1'b0);
    draw(300, 200, 307, 220, "R5 oct1", 1'b0);
    draw(300, 200, 293, 220, "R5 oct2", 1'b0);
    draw(300, 200, 280, 207, "R5 oct3", 1'b0);
    draw(300, 200, 280, 193, "R5 oct4", 1'b0);
    draw(300, 200, 293, 180, "R5 oct5", 1'b0);
    draw(300, 200, 307, 180, "R5 oct6", 1'b0);
    draw(300, 200, 320, 193, "R5 oct7", 1'b0);
    draw(100, 100, 112, 88, "R5 diagonal tie", 1'b0);
    draw(50, 60, 50, 75, "R6 vertical", 1'b0);
    draw(70, 10, 40, 10, "R6 horizontal left", 1'b0);
    draw(123, 45, 123, 45, "R9 zero length", 1'b0);
    draw(630, 5, 650, 6, "R10 past right edge", 1'b0);
    draw(0, 0, 1023, 511, "R3 full span", 1'b0);
    draw(10, 10, 60, 30, "R8 start while busy", 1'b1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule